// File: doc/BRIEF.md
# Dual-Rail Precharged Key-Mix and Substitution Byte Path

This block is one round slice of a byte cipher, written in dual-rail precharge form. An internal 8-bit linear feedback shift register supplies one plaintext byte per capture cycle. The byte is mixed with an 8-bit key by exclusive-or and then passed through the AES substitution function, which is computed as logic rather than read from a table. A true rail and a false rail carry each bit: logic 1 is (T,F) = (1,0), logic 0 is (0,1), and the invalid precharged state is (0,0).

Every dual-rail gate takes two global phase inputs, a precharge level and an evaluation enable, beside its data inputs. The evaluation window is open only while the enable is high and precharge is low. Outside the window every gate output sits at (0,0). Inside the window a gate switches only once all of its input pairs are valid, so each gate makes one transition per cycle. A pair of byte registers, one per rail, captures the substitution result at a rising edge that falls inside an open window. Both rails share the reset, the clock and the phase inputs.

Top module: `dr_sbox_round`

## Requirements
- R1: The evaluation window is open only when `evw_i`=1 and `pchg_i`=0. In the other three combinations both `ev_t_o` and `ev_f_o` read 8'h00.
- R2: After reset `pt_o` holds the seed 8'h01. At each rising edge inside an open window it advances to {q[6:0], q[7]^q[5]^q[4]^q[3]}. It is never zero.
- R3: While the window is open, `ev_t_o` equals S(`pt_o` ^ `key_i`), where S is the AES substitution (multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapped to 0, followed by the affine map with constant 8'h63). `ev_f_o` equals its bitwise complement.
- R4: At a rising edge inside an open window, `ct_t_o` takes the value of `ev_t_o` and `ct_f_o` takes the value of `ev_f_o`.
- R5: At a rising edge with the window closed, `ct_t_o`, `ct_f_o` and `pt_o` keep their values.
- R6: `ct_f_o` is the bitwise complement of `ct_t_o` at all times. After reset `ct_t_o`=8'h00 and `ct_f_o`=8'hFF.
- R7: Driving `rst_n` low resets the registers at once, without waiting for a clock edge. After `rst_n` rises, the first capture can take place no earlier than the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| pchg_i | input | 1 | Global precharge level, shared by both rails |
| evw_i | input | 1 | Global evaluation enable, shared by both rails |
| key_i | input | 8 | Round key byte |
| pt_o | output | 8 | Current plaintext byte from the shift register |
| ev_t_o | output | 8 | True-rail substitution output |
| ev_f_o | output | 8 | False-rail substitution output |
| ct_t_o | output | 8 | True-rail result register |
| ct_f_o | output | 8 | False-rail result register |

## Verification
On every clock edge, the assertions check four things: both rails read zero while the window is closed, the rails are complementary while it is open, the result registers stay complementary, and no register changes after an edge that falls in a closed window. The assertions also confirm that the plaintext register never reaches zero. Only the bench scenarios can show that the values are correct. To do so, they sweep the full 255-state plaintext sequence under several keys and compare each result against a substitution model that finds inverses by search. They also cover every combination of the phase inputs, and they check when captures first happen after reset is released and that a reset asserted mid-run takes effect at once.

// File: rtl/drp_pkg.sv
package drp_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] AFF_C = 8'h63;
  localparam logic [BYTE_W-1:0] RED_P = 8'h1B;

  // GF(2^8) multiply, shift-and-add with reduction
  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? RED_P : '0);
    end
    return acc;
  endfunction

  // Inverse as x^254 (0 maps to 0)
  function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] r;
    logic [BYTE_W-1:0] p;
    r = 8'h01;
    p = x;
    for (int i = 1; i < BYTE_W; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] affine(input logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] b;
    for (int i = 0; i < BYTE_W; i++) begin
      b[i] = x[i] ^ x[3'(i + 4)] ^ x[3'(i + 5)] ^ x[3'(i + 6)] ^ x[3'(i + 7)]
             ^ AFF_C[i];
    end
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] sbox_byte(input logic [BYTE_W-1:0] x);
    return affine(gf_inv(x));
  endfunction

endpackage

// File: rtl/drp_rst_sync.sv
module drp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/drp_lfsr.sv
module drp_lfsr #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    SEED = 8'h01,
  parameter logic [W-1:0]    TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;
  logic         fb;

  always_comb begin
    fb   = ^(q_r & TAPS);
    q_nx = en ? {q_r[W-2:0], fb} : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= SEED;
    else        q_r <= q_nx;
  end

  assign q = q_r;

  // R2: a maximal-length sequence never enters the all-zero state
  p_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_r != '0);
  // R2: an enabled step always moves to a different state
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q_r != $past(q_r)));
endmodule

// File: rtl/drp_xor.sv
module drp_xor #(
  parameter int W = 8
) (
  input  logic         pchg,
  input  logic         evw,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  output logic [W-1:0] y_t,
  output logic [W-1:0] y_f
);
  // one dual-rail gate per bit: four data inputs plus the two phase inputs
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic win;
    logic ready;
    logic val;
    always_comb begin
      win    = evw & ~pchg;
      ready  = (a_t[i] ^ a_f[i]) & (b_t[i] ^ b_f[i]);
      val    = a_t[i] ^ b_t[i];
      y_t[i] = win & ready & val;
      y_f[i] = win & ready & ~val;
    end
  end
endmodule

// File: rtl/drp_sbox.sv
module drp_sbox
  import drp_pkg::*;
(
  input  logic              pchg,
  input  logic              evw,
  input  logic [BYTE_W-1:0] in_t,
  input  logic [BYTE_W-1:0] in_f,
  output logic [BYTE_W-1:0] out_t,
  output logic [BYTE_W-1:0] out_f
);
  logic win;
  logic all_ok;

  // evaluate only once every input pair is valid and the window is open
  always_comb begin
    win    = evw & ~pchg;
    all_ok = win & (&(in_t ^ in_f));
  end

  // core 0 works from the true rail, core 1 from the false rail
  for (genvar c = 0; c < 2; c++) begin : g_core
    logic [BYTE_W-1:0] src;
    logic [BYTE_W-1:0] res;
    if (c == 0) begin : g_src_t
      assign src = in_t;
    end else begin : g_src_f
      assign src = ~in_f;
    end
    always_comb res = sbox_byte(src);
    if (c == 0) begin : g_out_t
      assign out_t = all_ok ? res : '0;
    end else begin : g_out_f
      assign out_f = all_ok ? ~res : '0;
    end
  end
endmodule

// File: rtl/drp_reg.sv
module drp_reg #(
  parameter int           W     = 8,
  parameter logic [W-1:0] RST_T = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_t,
  input  logic [W-1:0] d_f,
  output logic [W-1:0] q_t,
  output logic [W-1:0] q_f
);
  logic [W-1:0] t_r, f_r, t_nx, f_nx;

  always_comb begin
    t_nx = en ? d_t : t_r;
    f_nx = en ? d_f : f_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_r <= RST_T;
      f_r <= ~RST_T;
    end else begin
      t_r <= t_nx;
      f_r <= f_nx;
    end
  end

  assign q_t = t_r;
  assign q_f = f_r;

  // R6: the two rail registers always hold complementary valid data
  p_compl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_t == ~q_f);
  // R5: no capture without enable
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(q_t) && $stable(q_f)));
endmodule

// File: rtl/dr_sbox_round.sv
module dr_sbox_round
  import drp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PT_SEED = 8'h01,
  parameter logic [BYTE_W-1:0] PT_TAPS = 8'hB8,
  parameter int                SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pchg_i,
  input  logic              evw_i,
  input  logic [BYTE_W-1:0] key_i,
  output logic [BYTE_W-1:0] pt_o,
  output logic [BYTE_W-1:0] ev_t_o,
  output logic [BYTE_W-1:0] ev_f_o,
  output logic [BYTE_W-1:0] ct_t_o,
  output logic [BYTE_W-1:0] ct_f_o
);
  logic              rst_sn;
  logic              cap_en;
  logic [BYTE_W-1:0] pt;
  logic [BYTE_W-1:0] mx_t, mx_f;
  logic [BYTE_W-1:0] sb_t, sb_f;

  drp_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  // capture enable shared by every register on both rails
  always_comb cap_en = evw_i & ~pchg_i;

  drp_lfsr #(.W(BYTE_W), .SEED(PT_SEED), .TAPS(PT_TAPS)) u_src (
    .clk(clk), .rst_n(rst_sn), .en(cap_en), .q(pt)
  );

  drp_xor #(.W(BYTE_W)) u_mix (
    .pchg(pchg_i), .evw(evw_i),
    .a_t(pt), .a_f(~pt), .b_t(key_i), .b_f(~key_i),
    .y_t(mx_t), .y_f(mx_f)
  );

  drp_sbox u_sub (
    .pchg(pchg_i), .evw(evw_i),
    .in_t(mx_t), .in_f(mx_f),
    .out_t(sb_t), .out_f(sb_f)
  );

  drp_reg #(.W(BYTE_W), .RST_T('0)) u_out (
    .clk(clk), .rst_n(rst_sn), .en(cap_en),
    .d_t(sb_t), .d_f(sb_f), .q_t(ct_t_o), .q_f(ct_f_o)
  );

  assign pt_o   = pt;
  assign ev_t_o = sb_t;
  assign ev_f_o = sb_f;

  // R1: closed window leaves both rails precharged
  p_closed_zero_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (!evw_i || pchg_i) |-> (sb_t == '0 && sb_f == '0));
  // R3: open window gives a complementary valid pair
  p_open_compl_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (evw_i && !pchg_i) |-> (sb_t == ~sb_f));
  // R5: closed window at an edge leaves the plaintext unchanged
  p_pt_hold_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (!evw_i || pchg_i) |=> $stable(pt));
endmodule

// File: tb/dr_sbox_round_bench.sv
module dr_sbox_round_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pchg, evw;
  logic [7:0] key;
  logic [7:0] pt_o, ev_t, ev_f, ct_t, ct_f;

  int checks = 0;
  int fails  = 0;
  logic [7:0] pt_m, ct_m;

  always #10 clk = ~clk;

  dr_sbox_round u_dr_sbox_round (
    .clk(clk), .rst_n(rst_n), .pchg_i(pchg), .evw_i(evw), .key_i(key),
    .pt_o(pt_o), .ev_t_o(ev_t), .ev_f_o(ev_f), .ct_t_o(ct_t), .ct_f_o(ct_f)
  );

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv = 8'h00;
    logic [7:0] r;
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    r = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
        ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return r;
  endfunction

  function automatic logic [7:0] m_next(input logic [7:0] q);
    return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // one system cycle; mode 0 open, 1 both high, 2 both low, 3 precharge only
  task automatic cycle(input int mode, input logic [7:0] k);
    @(posedge clk);
    #2;
    pchg = 1'b1; evw = 1'b0; key = k;
    #3;
    chk("R1 closed ev_t", ev_t, 8'h00);
    chk("R1 closed ev_f", ev_f, 8'h00);
    chk("R4/R5 ct_t", ct_t, ct_m);
    chk("R6 ct_f", ct_f, ~ct_m);
    chk("R2 pt", pt_o, pt_m);
    #3;
    pchg = (mode == 1 || mode == 3);
    evw  = (mode == 0 || mode == 1);
    #7;
    if (mode == 0) begin
      chk("R3 ev_t", ev_t, m_sbox(pt_m ^ k));
      chk("R3 ev_f", ev_f, ~m_sbox(pt_m ^ k));
      ct_m = m_sbox(pt_m ^ k);
      pt_m = m_next(pt_m);
    end else begin
      chk("R1 mode ev_t", ev_t, 8'h00);
      chk("R1 mode ev_f", ev_f, 8'h00);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] keys [5] = '{8'h00, 8'h5A, 8'hA5, 8'hFF, 8'h3C};
    rst_n = 1'b0; pchg = 1'b1; evw = 1'b0; key = 8'h00;
    pt_m = 8'h01; ct_m = 8'h00;
    chk("R3 model", m_sbox(8'h53), 8'hED);
    #55 rst_n = 1'b1; pchg = 1'b0; evw = 1'b1;
    #5;
    chk("R6 reset ct_t", ct_t, 8'h00);
    chk("R6 reset ct_f", ct_f, 8'hFF);
    chk("R2 reset pt", pt_o, 8'h01);
    #15; // after edge at 70
    chk("R7 edge1 ct_t", ct_t, 8'h00);
    #20; // after edge at 90
    chk("R7 edge2 ct_t", ct_t, 8'h00);
    chk("R7 edge2 pt", pt_o, 8'h01);
    #20; // after edge at 110: first capture
    chk("R4 first ct_t", ct_t, 8'h7C);
    chk("R4 first ct_f", ct_f, 8'h83);
    chk("R2 first step", pt_o, 8'h02);
    #2 pchg = 1'b1; evw = 1'b0;
    pt_m = 8'h02; ct_m = 8'h7C;

    // full plaintext sequence under several keys
    foreach (keys[j]) for (int i = 0; i < 255; i++) cycle(0, keys[j]);
    // every phase combination, interleaved
    for (int i = 0; i < 400; i++) cycle(i % 4, 8'(i * 37));
    for (int i = 0; i < 40; i++) cycle((i % 3 == 0) ? 0 : 2, 8'hC3);
    cycle(2, 8'h11);
    @(posedge clk);
    #5;
    chk("R5 final ct_t", ct_t, ct_m);
    chk("R5 final pt", pt_o, pt_m);

    // asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    chk("R7 async ct_t", ct_t, 8'h00);
    chk("R7 async ct_f", ct_f, 8'hFF);
    chk("R7 async pt", pt_o, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule